// File: doc/BRIEF.md
# I2C Register Bank Target

This block is a target (slave) device on a two-wire I2C bus. It gives an external bus controller access to a small bank of byte-wide registers. Both bus lines are sampled with the system clock through two-flop synchronizers, and edges are found on the synchronized copies. The data line is never driven high. The block only asserts a pull-low enable, and the pad logic outside turns that into an open-drain output. The bus address is fixed by a parameter.

A write transfer works as follows. The first byte after the address loads an internal register pointer, and each later byte is stored at the pointer. Reads shift out the register at the pointer. The pointer is kept across a repeated START and across STOP, so a pointer write followed by a read returns the selected register. The pointer steps once per data byte and wraps to register 0 after the last register.

Local logic sees every register on a flat parallel output. It can overwrite any register with a per-register load strobe.

Top module: `i2c_regbank_target`

## Requirements
- R1: After reset every register reads 0 on the parallel output, the pointer is 0 and the pull-low enable is off.
- R2: An address byte is sent MSB first. Its upper seven bits are the device address and its bit 0 selects the direction (0 = write, 1 = read). When the address matches, the target pulls SDA low through the whole high phase of the 9th clock.
- R3: An address byte that does not match is not acknowledged. Until the next START the target never pulls SDA low and changes no register.
- R4: In a write transfer the first byte after the address sets the pointer. Each further byte is stored in the register at the pointer. Every one of these bytes is acknowledged.
- R5: The pointer advances by one after each data byte written or read, and wraps from the last register to register 0.
- R6: A pointer byte of NREG or more is not acknowledged. The pointer keeps its old value, and the following bytes of that transfer are neither acknowledged nor stored.
- R7: A read-direction address that matches is acknowledged. The target then shifts out the register at the pointer MSB first, with each bit held steady while SCL is high.
- R8: When the controller acknowledges a read byte, the next register follows. When it does not, the target releases SDA and drives nothing until the next START.
- R9: The pointer keeps its value across a repeated START and across STOP.
- R10: A START or STOP at any bit position abandons the current byte. After a START the target expects an address byte. After a STOP it releases SDA.
- R11: A high bit of `load_en` copies the matching byte of `load_data` into that register on the next clock. The new value shows on `regs_o` and is returned by bus reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | NREG*8 | All registers, register i in bits [8i+7:8i] |
| load_en | input | NREG | Per-register local load strobe |
| load_data | input | NREG*8 | Local load values, same layout as regs_o |

## Verification
The hardest case to reach from the pins is a START or STOP that lands in the middle of a byte. A bus controller that follows the protocol never produces one. The bench therefore has its own bus model that sends a few bits, breaks off with a START or STOP, and then shows that the next transfer behaves as if it came straight after idle. A second hard case is pointer wrap-around during a read burst that also follows an earlier pointer write across a repeated START. Randomly placed burst writes and reads, with lengths that cross the last register, reach it many times against a register model kept in the bench.

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target #(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int AW = 3,
  localparam int NREG = 1 << AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull,
  output logic [NREG*8-1:0] regs_o,
  input  logic [NREG-1:0]   load_en,
  input  logic [NREG*8-1:0] load_data
);
  localparam logic [2:0] S_IDLE = 3'd0, S_RX = 3'd1, S_ACKTX = 3'd2, S_TX = 3'd3, S_ACKRX = 3'd4;

  logic [2:0]    scl_sr, sda_sr, state;
  logic [3:0]    bitcnt;
  logic [7:0]    sh;
  logic [AW-1:0] ptr;
  logic          addr_ph, ptr_ph, rw, m_ack;
  logic [7:0]    mem [NREG];

  wire scl_s = scl_sr[1], scl_d = scl_sr[2];
  wire sda_s = sda_sr[1], sda_d = sda_sr[2];
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  wire byte_end = state == S_RX && scl_fall && bitcnt == 4'd8;
  wire addr_hit = sh[7:1] == DEV_ADDR;
  wire ptr_ok   = (sh >> AW) == 8'd0;
  wire rx_ack   = addr_ph ? addr_hit : (ptr_ph ? ptr_ok : 1'b1);
  wire wr_en    = byte_end && !start_c && !stop_c && !addr_ph && !ptr_ph;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sr <= 3'b111;
      sda_sr <= 3'b111;
    end else begin
      scl_sr <= {scl_sr[1:0], scl_i};
      sda_sr <= {sda_sr[1:0], sda_i};
    end

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) mem[g] <= 8'h00;
        else if (load_en[g]) mem[g] <= load_data[g*8 +: 8];
        else if (wr_en && ptr == AW'(g)) mem[g] <= sh;
      assign regs_o[g*8 +: 8] = mem[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; bitcnt <= '0; sh <= '0; ptr <= '0;
      addr_ph <= 1'b0; ptr_ph <= 1'b0; rw <= 1'b0; m_ack <= 1'b0; sda_pull <= 1'b0;
    end else if (start_c) begin
      state <= S_RX; bitcnt <= '0; addr_ph <= 1'b1; sda_pull <= 1'b0;
    end else if (stop_c) begin
      state <= S_IDLE; sda_pull <= 1'b0;
    end else begin
      case (state)
        S_RX:
          if (scl_rise && bitcnt < 4'd8) begin
            sh <= {sh[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_end) begin
            if (rx_ack) begin
              sda_pull <= 1'b1;
              state <= S_ACKTX;
              if (addr_ph) begin
                rw <= sh[0];
                ptr_ph <= ~sh[0];
              end else if (ptr_ph) begin
                ptr <= sh[AW-1:0];
                ptr_ph <= 1'b0;
              end else ptr <= ptr + 1'b1;
            end else state <= S_IDLE;
          end
        S_ACKTX:
          if (scl_fall) begin
            addr_ph <= 1'b0;
            bitcnt <= '0;
            if (rw) begin
              state <= S_TX;
              sh <= mem[ptr];
              sda_pull <= ~mem[ptr][7];
            end else begin
              state <= S_RX;
              sda_pull <= 1'b0;
            end
          end
        S_TX:
          if (scl_rise) bitcnt <= bitcnt + 4'd1;
          else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_pull <= 1'b0;
              state <= S_ACKRX;
              ptr <= ptr + 1'b1;
            end else begin
              sh <= {sh[6:0], 1'b0};
              sda_pull <= ~sh[6];
            end
          end
        S_ACKRX:
          if (scl_rise) m_ack <= ~sda_s;
          else if (scl_fall) begin
            if (m_ack) begin
              state <= S_TX;
              bitcnt <= '0;
              sh <= mem[ptr];
              sda_pull <= ~mem[ptr][7];
            end else state <= S_IDLE;
          end
        default: state <= S_IDLE;
      endcase
    end
endmodule

module i2c_regbank_target_chk #(parameter int AW = 3) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          start_c,
  input logic          stop_c,
  input logic [2:0]    state,
  input logic [3:0]    bitcnt,
  input logic [AW-1:0] ptr,
  input logic          ptr_ph,
  input logic          sda_pull
);
  // R3
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd0 |-> !sda_pull);
  // R10
  start_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (state == 3'd1 && bitcnt == 4'd0));
  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (state == 3'd0 && !sda_pull));
  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(ptr) && !$past(ptr_ph)) |-> ptr == AW'($past(ptr) + 1'b1));
  // R7
  drive_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(sda_pull) && !$past(start_c) && !$past(stop_c)) |-> !$past(scl_s));
  // R2
  ack_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_pull) && state == 3'd2) |-> $past(bitcnt) == 4'd8);
endmodule

bind i2c_regbank_target i2c_regbank_target_chk #(.AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_sr[1]), .start_c(start_c), .stop_c(stop_c),
  .state(state), .bitcnt(bitcnt), .ptr(ptr), .ptr_ph(ptr_ph), .sda_pull(sda_pull));

// File: tb/i2c_regbank_target_test.sv
module i2c_regbank_target_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [6:0] ADDR = 7'h2A;

  logic clk = 0, rst_n = 0, scl = 1, sda_m = 1;
  logic [7:0]  load_en = '0;
  logic [63:0] load_data = '0;
  logic [63:0] regs_o;
  logic sda_pull;
  wire  sda_line = sda_m & ~sda_pull;

  int n_chk = 0, n_fail = 0, pull_cnt = 0;
  bit done = 0;
  logic [7:0] model [8];
  logic [7:0] buff [8];
  int ptr_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (sda_pull) pull_cnt <= pull_cnt + 1;

  i2c_regbank_target #(.DEV_ADDR(ADDR), .AW(3)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_pull(sda_pull),
    .regs_o(regs_o), .load_en(load_en), .load_data(load_data));

  function automatic int nxt(input int p); return (p + 1) % 8; endfunction
  function automatic bit ptr_acc(input logic [7:0] p); return p < 8'd8; endfunction
  function automatic logic [63:0] model_flat();
    logic [63:0] f;
    for (int i = 0; i < 8; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic q(); repeat (Q) @(negedge clk); endtask
  task automatic i2c_start(); sda_m = 1; q(); scl = 1; q(); sda_m = 0; q(); scl = 0; q(); endtask
  task automatic i2c_stop(); sda_m = 0; q(); scl = 1; q(); sda_m = 1; q(); endtask
  task automatic wbit(input logic b); sda_m = b; q(); scl = 1; q(); q(); scl = 0; q(); endtask
  task automatic rbit(output logic b); sda_m = 1; q(); scl = 1; q(); b = sda_line; q(); scl = 0; q(); endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic give_ack);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(~give_ack);
  endtask

  task automatic write_regs(input logic [7:0] p, input int n);
    logic ack;
    i2c_start();
    wbyte({ADDR, 1'b0}, ack); check("R2 write address ack", ack, 1);
    wbyte(p, ack);            check("R4 pointer ack", ack, 1);
    ptr_m = p;
    for (int i = 0; i < n; i++) begin
      wbyte(buff[i], ack); check("R4 data ack", ack, 1);
      model[ptr_m] = buff[i];
      ptr_m = nxt(ptr_m);
    end
    i2c_stop();
    check("R4 R5 registers after write", regs_o, model_flat());
  endtask

  task automatic read_regs(input bit setp, input logic [7:0] p, input int n);
    logic ack;
    logic [7:0] d;
    i2c_start();
    if (setp) begin
      wbyte({ADDR, 1'b0}, ack); check("R2 address ack", ack, 1);
      wbyte(p, ack);            check("R4 pointer ack", ack, 1);
      ptr_m = p;
      i2c_start();
    end
    wbyte({ADDR, 1'b1}, ack); check("R7 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      rbyte(d, i < n - 1);
      check("R7 R8 R9 read data", d, model[ptr_m]);
      ptr_m = nxt(ptr_m);
    end
    pull_cnt = 0;
    q(); q();
    check("R8 released after NACK", pull_cnt, 0);
    i2c_stop();
  endtask

  initial begin
    logic ack;
    void'($urandom(32'd20240607));
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 registers after reset", regs_o, 64'h0);
    check("R1 SDA released after reset", sda_pull, 0);
    read_regs(0, 0, 1);

    buff[0] = 8'hA5; buff[1] = 8'h3C; buff[2] = 8'hF0;
    write_regs(8'd2, 3);
    read_regs(1, 8'd2, 3);

    buff[0] = 8'h11; buff[1] = 8'h22; buff[2] = 8'h33; buff[3] = 8'h44;
    write_regs(8'd6, 4);
    check("R5 wrap stored reg0", regs_o[7:0], 8'h33);
    read_regs(1, 8'd7, 3);
    read_regs(0, 0, 2);

    pull_cnt = 0;
    i2c_start();
    wbyte({ADDR ^ 7'h01, 1'b0}, ack); check("R3 mismatch write no ack", ack, 0);
    wbyte(8'h00, ack);                check("R3 later byte no ack", ack, 0);
    wbyte(8'hFF, ack);                check("R3 later byte no ack", ack, 0);
    i2c_start();
    wbyte({ADDR ^ 7'h40, 1'b1}, ack); check("R3 mismatch read no ack", ack, 0);
    wbit(1'b0); wbit(1'b0);
    i2c_stop();
    check("R3 SDA never pulled", pull_cnt, 0);
    check("R3 registers unchanged", regs_o, model_flat());

    i2c_start();
    wbyte({ADDR, 1'b0}, ack); check("R2 address ack", ack, 1);
    wbyte(8'h08, ack);        check("R6 pointer 8 not acked", ack, 0);
    wbyte(8'h5A, ack);        check("R6 following byte not acked", ack, 0);
    i2c_stop();
    check("R6 registers unchanged", regs_o, model_flat());
    read_regs(0, 0, 1);

    i2c_start();
    wbit(1'b1); wbit(1'b0); wbit(1'b1); wbit(1'b1);
    i2c_start();
    wbyte({ADDR, 1'b0}, ack); check("R10 address after mid-byte START", ack, 1);
    wbit(1'b0); wbit(1'b1); wbit(1'b0);
    i2c_stop();
    check("R10 released after mid-byte STOP", sda_pull, 0);
    check("R10 nothing stored by cut byte", regs_o, model_flat());
    buff[0] = 8'hC3;
    write_regs(8'd4, 1);

    @(negedge clk);
    load_en = 8'b0010_0001;
    load_data = 64'h0000_9900_0000_0077;
    @(negedge clk);
    load_en = '0;
    model[0] = 8'h77; model[5] = 8'h99;
    check("R11 local load visible", regs_o, model_flat());
    read_regs(1, 8'd5, 1);
    read_regs(1, 8'd0, 1);

    for (int t = 0; t < 24; t++) begin
      int len;
      logic [7:0] p;
      len = 1 + int'($urandom_range(0, 4));
      p = 8'($urandom_range(0, 7));
      if ($urandom_range(0, 1) == 0) begin
        for (int i = 0; i < len; i++) buff[i] = 8'($urandom);
        write_regs(p, len);
      end else read_regs($urandom_range(0, 3) != 0, p, len);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule